// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves an 18-bit word between two ports, A and B, with one independent path per direction. Each path owns a single storage register that behaves in one of three ways, chosen by its control pins: it can pass the input straight to the far side, hold a word, or capture the input on a rising edge of that path's own capture clock. Every path has four control pins: an active-low output enable, a latch enable, a capture clock and an active-low capture-clock enable.

The core runs on one system clock `clk` with a synchronous active-low reset `rst_n`. Each path's capture clock is treated as a level and sampled by `clk`. A low-to-high change seen between two `clk` edges is taken as a capture edge. Pads are split into an input vector, an output vector and a drive flag, so no tri-state logic sits inside the core. The surrounding pad ring must not let both ports drive at once. That case is bus contention, and the bench checks for it.

Top module: `univ_bus_xcvr`

## Requirements
- R1: The synchronous active-low reset clears both storage registers to zero, so with the latch enable low both output vectors read 0 on the cycle after reset. The data path is WIDTH bits wide, 18 by default, and all bits including bit 17 pass.
- R2: While a path's latch enable is high, its output vector equals its input vector in the same cycle, with no register in between.
- R3: While the latch enable is low and no enabled capture edge occurs, the output shows the stored word and it does not change, even if the input changes.
- R4: With the latch enable low and the capture-clock enable low (0), a capture clock sampled at 0 and then at 1 on the next `clk` edge stores the input present at that edge. The stored word appears on the output after that `clk` edge.
- R5: While the capture-clock enable is high (1), rising capture-clock edges are ignored and the stored word is unchanged.
- R6: The latch enable takes priority over the capture clock. While it is high, the register loads the input on every `clk` edge. After it falls, the output keeps the word that was present at the last `clk` edge at which it was high.
- R7: The output enable is active low. The drive flag of a path's output port is 1 exactly while that path's enable is 0 and changes in the same cycle.
- R8: The two paths share no state. Activity on the B-to-A path leaves the stored A-to-B word unchanged, and the reverse holds too.
- R9: A high-to-low change of the capture clock stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Word received on port A |
| a_out | output | WIDTH | Word presented to port A (B-to-A path) |
| a_drive | output | 1 | Port A output drive flag |
| b_in | input | WIDTH | Word received on port B |
| b_out | output | WIDTH | Word presented to port B (A-to-B path) |
| b_drive | output | 1 | Port B output drive flag |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B latch enable (high = transparent) |
| ab_cap_clk | input | 1 | A-to-B capture clock |
| ab_cap_en_n | input | 1 | A-to-B capture-clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A latch enable (high = transparent) |
| ba_cap_clk | input | 1 | B-to-A capture clock |
| ba_cap_en_n | input | 1 | B-to-A capture-clock enable, active low |

## Verification
The transparent result (R2) and the drive flags (R7) are combinational, so the bench changes the inputs on the falling edge of `clk` and samples one nanosecond later, in the same cycle. A capture (R4), a reset (R1) or a release of the latch enable (R6) only shows after the next rising edge of `clk`. For these, the bench drives on a falling edge, waits for one rising edge and samples on the following falling edge. The hold cases (R3, R5, R9) are sampled at that same point, once or more, while the input is moved on purpose, so that any stray load would show.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_WIDTH = 18;
  parameter int unsigned XCVR_LANES = 2;

  typedef struct packed {
    logic oe_n;
    logic pass;
    logic cap_clk;
    logic cap_en_n;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  // Reset high so a capture clock already high at reset release is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic load;

  assign load = pass | capture;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic             clk_rise;
  logic             capture;
  logic [WIDTH-1:0] held;

  xcvr_rise_det u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ctrl.cap_clk),
    .rise  (clk_rise)
  );

  assign capture = clk_rise & ~ctrl.cap_en_n & ~ctrl.pass;

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .pass    (ctrl.pass),
    .capture (capture),
    .d       (din),
    .q       (held)
  );

  assign dout  = ctrl.pass ? din : held;
  assign drive = ~ctrl.oe_n;
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = XCVR_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_oe_n,
  input  logic             ab_pass,
  input  logic             ab_cap_clk,
  input  logic             ab_cap_en_n,
  input  logic             ba_oe_n,
  input  logic             ba_pass,
  input  logic             ba_cap_clk,
  input  logic             ba_cap_en_n
);
  localparam int unsigned NL = XCVR_LANES;

  lane_ctrl_t             ctrl  [NL];
  logic       [WIDTH-1:0] lin   [NL];
  logic       [WIDTH-1:0] lout  [NL];
  logic                   ldrv  [NL];

  // Lane 0 carries A to B, lane 1 carries B to A.
  assign ctrl[0] = '{oe_n: ab_oe_n, pass: ab_pass, cap_clk: ab_cap_clk, cap_en_n: ab_cap_en_n};
  assign ctrl[1] = '{oe_n: ba_oe_n, pass: ba_pass, cap_clk: ba_cap_clk, cap_en_n: ba_cap_en_n};
  assign lin[0]  = a_in;
  assign lin[1]  = b_in;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (ctrl[g]),
      .din   (lin[g]),
      .dout  (lout[g]),
      .drive (ldrv[g])
    );
  end

  assign b_out   = lout[0];
  assign b_drive = ldrv[0];
  assign a_out   = lout[1];
  assign a_drive = ldrv[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_oe_n,
  input logic             ab_pass,
  input logic             ab_cap_clk,
  input logic             ab_cap_en_n,
  input logic             ba_oe_n,
  input logic             ba_pass,
  input logic             ba_cap_clk,
  input logic             ba_cap_en_n
);
  logic ab_ck_q;
  logic ba_ck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_ck_q <= 1'b1;
      ba_ck_q <= 1'b1;
    end else begin
      ab_ck_q <= ab_cap_clk;
      ba_ck_q <= ba_cap_clk;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n ##1 !ab_pass |-> b_out == '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !(ab_cap_clk && !ab_ck_q && !ab_cap_en_n)) ##1 !ab_pass |-> $stable(b_out));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !ab_cap_en_n && ab_cap_clk && !ab_ck_q) ##1 !ab_pass |-> b_out == $past(a_in));

  assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && ba_cap_en_n) ##1 !ba_pass |-> $stable(a_out));

  assert_pass_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass ##1 !ab_pass |-> b_out == $past(a_in));

  assert_lane_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass ##1 !ba_pass |-> a_out == $past(b_in));
endmodule

bind univ_bus_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_xcvr_checker (.*);

// File: tb/test_univ_bus_xcvr.sv
`timescale 1ns/1ps
module test_univ_bus_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive;
  logic ab_oe_n = 1'b1, ab_pass = 1'b0, ab_cap_clk = 1'b0, ab_cap_en_n = 1'b0;
  logic ba_oe_n = 1'b1, ba_pass = 1'b0, ba_cap_clk = 1'b0, ba_cap_en_n = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  univ_bus_xcvr #(.WIDTH(W)) i_univ_bus_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_cap_clk(ab_cap_clk), .ab_cap_en_n(ab_cap_en_n),
    .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_cap_clk(ba_cap_clk), .ba_cap_en_n(ba_cap_en_n)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Contention monitor: the bench never enables both directions together.
  always @(negedge clk) begin
    if (rst_n && a_drive === 1'b1 && b_drive === 1'b1) begin
      checks++;
      errors++;
      $display("FAIL R7: contention actual=11 expected=not both driving");
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    #1;
    check("R1 b_out after reset", b_out, '0);
    check("R1 a_out after reset", a_out, '0);
    check("R7 drives idle", {16'd0, a_drive, b_drive}, '0);
  endtask

  task automatic t_transparent();
    @(negedge clk);
    ab_pass = 1'b1; a_in = 18'h2AAAA;
    #1 check("R2 transparent 2AAAA, bit17 R1", b_out, 18'h2AAAA);
    a_in = 18'h15555;
    #1 check("R2 transparent 15555", b_out, 18'h15555);
  endtask

  task automatic t_release();
    step();
    ab_pass = 1'b0; a_in = 18'h3FFFF;
    #1 check("R6 keeps last passed word", b_out, 18'h15555);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      a_in = 18'h00F00 + 18'(i);
      step();
      check("R3 hold with moving input", b_out, 18'h15555);
    end
  endtask

  task automatic t_capture();
    a_in = 18'h12345; ab_cap_clk = 1'b1;
    #1 check("R4 not before clk edge", b_out, 18'h15555);
    step();
    check("R4 captured", b_out, 18'h12345);
    a_in = 18'h0AAAA;
    step();
    check("R3 clock held high no recapture", b_out, 18'h12345);
  endtask

  task automatic t_fall();
    ab_cap_clk = 1'b0; a_in = 18'h0F0F0;
    step();
    check("R9 falling edge ignored", b_out, 18'h12345);
  endtask

  task automatic t_gated();
    ab_cap_en_n = 1'b1; a_in = 18'h00ABC; ab_cap_clk = 1'b1;
    step();
    check("R5 gated edge ignored", b_out, 18'h12345);
    ab_cap_clk = 1'b0;
    step();
    ab_cap_en_n = 1'b0;
    step();
  endtask

  task automatic t_oe();
    ab_oe_n = 1'b0;
    #1 check("R7 b_drive on", {17'd0, b_drive}, 18'd1);
    check("R7 a_drive off", {17'd0, a_drive}, 18'd0);
    ab_oe_n = 1'b1;
    #1 check("R7 b_drive off", {17'd0, b_drive}, 18'd0);
    ba_oe_n = 1'b0;
    #1 check("R7 a_drive on", {17'd0, a_drive}, 18'd1);
    ba_oe_n = 1'b1;
    step();
  endtask

  task automatic t_independent();
    b_in = 18'h3C3C3; ba_pass = 1'b1;
    step();
    ba_pass = 1'b0; b_in = 18'h11111;
    #1 check("R8 B-to-A keeps passed word", a_out, 18'h3C3C3);
    check("R8 A-to-B untouched", b_out, 18'h12345);
    ba_cap_clk = 1'b1; b_in = 18'h22222;
    step();
    check("R4 B-to-A capture", a_out, 18'h22222);
    check("R8 A-to-B still untouched", b_out, 18'h12345);
    ba_cap_clk = 1'b0;
    step();
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    #1 check("R1 mid-run reset b_out", b_out, '0);
    check("R1 mid-run reset a_out", a_out, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_transparent();
    t_release();
    t_hold();
    t_capture();
    t_fall();
    t_gated();
    t_oe();
    t_independent();
    t_reset_again();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule